// File: doc/BRIEF.md
# Buffered 16-bit Timer

This block is a 16-bit up-counter reached over an 8-bit register bus. Software sees four byte addresses: the counter low byte, the counter high byte, a control register and a status register. The counter advances from either the system clock or an external clock input. An external input is sampled through a synchronizer and counted on its rising edges. A two-bit field selects a prescale ratio of 1, 2, 4 or 8 ahead of the counter, and a run bit gates counting.

In the wide access mode, the high-byte address no longer reaches the live counter. It reaches a holding byte instead. A read of the low byte captures the live high byte into that holding byte, so a low-then-high read pair always gives one consistent 16-bit value. A write of the low byte loads the whole counter at once, with the high half taken from the holding byte. A wrap from FFFFh to 0000h sets a sticky overflow flag, which raises the interrupt output when enabled.

A special-event input clears the counter so that an external compare can turn the timer into a periodic counter. This clear never sets the overflow flag. A software write to the counter in the same cycle takes precedence over it.

Top module: `buf_timer16`

## Requirements
- R1: After reset every register reads 00h at all four addresses (0 low, 1 high, 2 control, 3 status) and `irq` is low.
- R2: With control bit 0 (run) set and the internal source, the counter advances once every 2^P clock cycles, where P is control bits 5:4 (00=/1, 01=/2, 10=/4, 11=/8); with run clear it holds its value.
- R3: Advancing from FFFFh gives 0000h and sets the overflow flag (status bit 0). The flag stays set until software writes status bit 0 as 0. `irq` is high exactly when the flag and the enable (status bit 1) are both set.
- R4: With control bit 7 (wide mode) set, address 1 reads and writes the holding byte. A read of address 0 copies the live high byte into the holding byte at that clock edge, so a following address-1 read matches the low byte read even across a carry.
- R5: In wide mode, a write to address 1 leaves the live counter untouched. A write to address 0 loads the low byte from the bus and the high byte from the holding byte in the same cycle.
- R6: With wide mode clear, address 1 reads and writes the live counter high byte directly.
- R7: The prescaler restarts only on a write to address 0; a write to address 1 does not disturb its phase.
- R8: A pulse on `evt_reset` sets the counter to 0000h at the next edge, and never sets the overflow flag, even when the counter held FFFFh.
- R9: A counter write (address 0, or address 1 in narrow mode) in the same cycle as `evt_reset` takes effect and the reset is dropped.
- R10: With control bit 1 set, the counter advances (through the prescaler) once per rising edge of `ext_clk_in`, the count landing on the third clock edge after the input rises; the system clock alone does not advance it.
- R11: Address 2 reads back control bits 7, 5, 4, 1 and 0 as written, with the other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address (0 low, 1 high, 2 control, 3 status) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_clk_in | input | 1 | External count source, asynchronous |
| evt_reset | input | 1 | Special-event counter clear, one cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a wide-mode read pair that straddles a carry into the high byte. A wrong design would then pair the new high byte with the old low byte. The bench loads 12FEh with run clear, starts counting at divide-by-one, and reads the low byte in the exact cycle the low byte shows FFh. It then reads the high byte after the carry has happened. The prescaler phase checks use the same exact-cycle timing: a high write and a low write are placed at a known prescaler phase, and the cycle of the next count is checked.

// File: rtl/buf_timer16.sv
module buf_timer16 #(
  parameter int BW  = 8,
  parameter int PSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          ext_clk_in,
  input  logic          evt_reset,
  output logic          irq
);
  localparam int CW  = 2 * BW;
  localparam int PCW = (1 << PSW) - 1;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2, A_ST = 2'd3;

  logic [CW-1:0]  cnt;
  logic [BW-1:0]  hbuf;
  logic           wide, ext_sel, run;
  logic [PSW-1:0] psc_sel;
  logic [PCW-1:0] psc, psc_lim;
  logic           ovf_flag, ovf_ien;
  logic [1:0]     ext_sync;
  logic           ext_prev;
  logic [BW-1:0]  ctl_rd;

  wire wr_lo  = bus_wr && bus_addr == A_LO;
  wire wr_hi  = bus_wr && bus_addr == A_HI;
  wire wr_ctl = bus_wr && bus_addr == A_CTL;
  wire wr_st  = bus_wr && bus_addr == A_ST;
  wire rd_lo  = bus_rd && bus_addr == A_LO;

  wire ext_rise = ext_sync[1] && !ext_prev;
  wire tick     = run && (ext_sel ? ext_rise : 1'b1);
  assign psc_lim = PCW'((1 << psc_sel) - 1);
  wire step     = tick && psc == psc_lim;
  wire cnt_wr   = wr_lo || (wr_hi && !wide);
  wire wrap     = step && !cnt_wr && !evt_reset && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[0], ext_clk_in};
      ext_prev <= ext_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psc <= '0;
    else if (wr_lo)   psc <= '0;
    else if (tick)    psc <= step ? '0 : psc + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (wr_lo)            cnt <= {wide ? hbuf : cnt[CW-1:BW], bus_wdata};
    else if (wr_hi && !wide)   cnt <= {bus_wdata, cnt[BW-1:0]};
    else if (evt_reset)        cnt <= '0;
    else if (step)             cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hbuf <= '0;
    else if (wide && wr_hi)   hbuf <= bus_wdata;
    else if (wide && rd_lo)   hbuf <= cnt[CW-1:BW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide    <= 1'b0;
      psc_sel <= '0;
      ext_sel <= 1'b0;
      run     <= 1'b0;
    end else if (wr_ctl) begin
      wide    <= bus_wdata[BW-1];
      psc_sel <= bus_wdata[4 +: PSW];
      ext_sel <= bus_wdata[1];
      run     <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ovf_ien  <= 1'b0;
    end else begin
      if (wrap)       ovf_flag <= 1'b1;
      else if (wr_st) ovf_flag <= ovf_flag & bus_wdata[0];
      if (wr_st)      ovf_ien  <= bus_wdata[1];
    end
  end

  always_comb begin
    ctl_rd          = '0;
    ctl_rd[BW-1]    = wide;
    ctl_rd[4 +: PSW] = psc_sel;
    ctl_rd[1]       = ext_sel;
    ctl_rd[0]       = run;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LO:  bus_rdata = cnt[BW-1:0];
      A_HI:  bus_rdata = wide ? hbuf : cnt[CW-1:BW];
      A_CTL: bus_rdata = ctl_rd;
      A_ST:  bus_rdata = {{(BW-2){1'b0}}, ovf_ien, ovf_flag};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = ovf_flag && ovf_ien;
endmodule

// File: rtl/buf_timer16_chk.sv
module buf_timer16_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [BW-1:0] bus_wdata,
  input logic          evt_reset,
  input logic [2*BW-1:0] cnt,
  input logic [BW-1:0] hbuf,
  input logic          wide,
  input logic          run,
  input logic          ovf_flag
);
  p_run_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr && !evt_reset) |=> $stable(cnt));

  p_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == {(2*BW){1'b1}}));

  p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && bus_rd && bus_addr == 2'd0) |=> (hbuf == $past(cnt[2*BW-1:BW])));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && bus_wr && bus_addr == 2'd0) |=> (cnt == {$past(hbuf), $past(bus_wdata)}));

  p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_reset && !(bus_wr && !bus_addr[1])) |=> (cnt == '0 && !$rose(ovf_flag)));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && evt_reset) |=> (cnt[BW-1:0] == $past(bus_wdata)));
endmodule

bind buf_timer16 buf_timer16_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .evt_reset(evt_reset), .cnt(cnt), .hbuf(hbuf),
  .wide(wide), .run(run), .ovf_flag(ovf_flag)
);

// File: tb/buf_timer16_test.sv
`timescale 1ns/1ps
module buf_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0, evt_reset = 1'b0;
  logic       irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] v;

  localparam logic [1:0] LO = 2'd0, HI = 2'd1, CTL = 2'd2, ST = 2'd3;

  always #2.5 clk = ~clk;

  buf_timer16 uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_in(ext_clk_in), .evt_reset(evt_reset), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = 1'b1; repeat (3) @(negedge clk);
      ext_clk_in = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R1 reset addr %0d", a), {8'h0, v}, 16'h0);
    end
    check("R1 reset irq", {15'h0, irq}, 16'h0);

    // R2 prescale sweep, internal source
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k <= 20; k++) begin
        wr(CTL, 8'(p << 4));
        wr(HI, 8'h00);
        wr(LO, 8'h00);
        wr(CTL, 8'((p << 4) | 1));
        repeat (k) @(negedge clk);
        rd(LO, v);
        check($sformatf("R2 div p=%0d k=%0d", p, k), {8'h0, v}, 16'(k >> p));
      end
    end
    wr(CTL, 8'h00);
    wr(HI, 8'h00); wr(LO, 8'h09);
    repeat (10) @(negedge clk);
    rd(LO, v);
    check("R2 run clear holds", {8'h0, v}, 16'h0009);

    // R11 control readback
    wr(CTL, 8'hFF);
    rd(CTL, v);
    check("R11 ctl readback", {8'h0, v}, 16'h00B3);
    wr(CTL, 8'h00);

    // R3 overflow
    wr(HI, 8'hFF); wr(LO, 8'hFE); wr(ST, 8'h02);
    wr(CTL, 8'h01);
    @(negedge clk);
    check("R3 no irq before wrap", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R3 irq after wrap", {15'h0, irq}, 16'h1);
    wr(CTL, 8'h00);
    rd(HI, v);
    check("R3 wrapped high", {8'h0, v}, 16'h0000);
    repeat (8) @(negedge clk);
    rd(ST, v);
    check("R3 flag sticky", {8'h0, v}, 16'h0003);
    wr(ST, 8'h01);
    check("R3 irq masked", {15'h0, irq}, 16'h0);
    rd(ST, v);
    check("R3 flag kept on write 1", {8'h0, v}, 16'h0001);
    wr(ST, 8'h02);
    rd(ST, v);
    check("R3 flag cleared", {8'h0, v}, 16'h0002);
    check("R3 irq low after clear", {15'h0, irq}, 16'h0);

    // R8 special-event reset at FFFF
    wr(HI, 8'hFF); wr(LO, 8'hFF);
    wr(CTL, 8'h01);
    evt_reset = 1'b1;
    @(negedge clk);
    evt_reset = 1'b0;
    rd(LO, v);
    check("R8 evt clears low", {8'h0, v}, 16'h0000);
    rd(HI, v);
    check("R8 evt clears high", {8'h0, v}, 16'h0000);
    wr(CTL, 8'h00);
    rd(ST, v);
    check("R8 no flag from evt", {8'h0, v}, 16'h0002);

    // R9 write beats evt
    bus_addr = LO; bus_wdata = 8'h55; bus_wr = 1'b1; evt_reset = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt_reset = 1'b0;
    rd(LO, v);
    check("R9 low write wins", {8'h0, v}, 16'h0055);
    bus_addr = HI; bus_wdata = 8'h66; bus_wr = 1'b1; evt_reset = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; evt_reset = 1'b0;
    rd(HI, v);
    check("R9 high write wins (R6 direct)", {8'h0, v}, 16'h0066);
    rd(LO, v);
    check("R9 low kept", {8'h0, v}, 16'h0055);

    // R4 / R5 wide mode
    wr(HI, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'h80);
    wr(HI, 8'h12);
    rd(HI, v);
    check("R4 wide high reads buffer", {8'h0, v}, 16'h0012);
    wr(CTL, 8'h00);
    rd(HI, v);
    check("R5 buffer write leaves live high", {8'h0, v}, 16'h0000);
    wr(CTL, 8'h80);
    wr(LO, 8'hFE);
    wr(CTL, 8'h00);
    rd(HI, v);
    check("R5 commit high", {8'h0, v}, 16'h0012);
    rd(LO, v);
    check("R5 commit low", {8'h0, v}, 16'h00FE);
    wr(CTL, 8'h81);
    @(negedge clk);
    rd(LO, v);
    check("R4 coherent low", {8'h0, v}, 16'h00FF);
    rd(HI, v);
    check("R4 coherent high across carry", {8'h0, v}, 16'h0012);
    wr(CTL, 8'h00);
    rd(HI, v);
    check("R6 narrow live high", {8'h0, v}, 16'h0013);

    // R7 high write keeps prescaler phase
    wr(CTL, 8'h30); wr(HI, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'hB1);
    repeat (5) @(negedge clk);
    wr(HI, 8'h77);
    @(negedge clk);
    rd(LO, v);
    check("R7 no early step", {8'h0, v}, 16'h0000);
    rd(LO, v);
    check("R7 high write keeps phase", {8'h0, v}, 16'h0001);
    // R7 low write restarts prescaler
    wr(CTL, 8'h30); wr(HI, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'h31);
    repeat (5) @(negedge clk);
    wr(LO, 8'h40);
    repeat (7) @(negedge clk);
    rd(LO, v);
    check("R7 low write restarts phase", {8'h0, v}, 16'h0040);
    rd(LO, v);
    check("R7 step after full period", {8'h0, v}, 16'h0041);

    // R10 external source
    wr(CTL, 8'h00); wr(HI, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'h03);
    ext_pulses(5);
    repeat (4) @(negedge clk);
    rd(LO, v);
    check("R10 ext count div1", {8'h0, v}, 16'h0005);
    repeat (20) @(negedge clk);
    rd(LO, v);
    check("R10 system clock ignored", {8'h0, v}, 16'h0005);
    wr(CTL, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'h13);
    ext_pulses(6);
    repeat (4) @(negedge clk);
    rd(LO, v);
    check("R10 ext count div2", {8'h0, v}, 16'h0003);
    wr(CTL, 8'h00); wr(LO, 8'h00);
    wr(CTL, 8'h03);
    ext_clk_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(LO, v);
    check("R10 not yet counted", {8'h0, v}, 16'h0000);
    rd(LO, v);
    check("R10 counted on third edge", {8'h0, v}, 16'h0001);
    ext_clk_in = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule